// File: doc/BRIEF.md
# Sequence Call and Termination Controller

This block owns the program counter of a command-sequence engine. It keeps the current PC, a stack of return points for nested sequence calls, and one slot that holds the start address of a sequence waiting to run. Each cycle the instruction decoder hands it at most one control command. The command is a plain step, a jump, a taken branch, a call, a return, an exit, a terminate or an abort, and it comes with a target address. For a call, the target is the start address that a separate lookup table has already resolved from the sequence ID.

Requests to run a sequence arrive on a separate launch input. When the engine is idle, a launch starts at once. While a sequence runs, the launch address waits in the pending slot. A terminate then hands control to that waiting sequence. An abort throws it away. An exit only acts as a return when the current code was reached through a call. At the top level, an exit ends the sequence the same way a terminate does.

Top module: `seqctl_top`

## Requirements
- R1: While rst_n is low and on the first cycle after it, pc equals RESET_PC (default 0), and running, seq_start, call_ovf and ret_unf are all low. The call stack and the pending slot are empty.
- R2: While running is low, cmd_valid and cmd_code have no effect and pc holds. A launch_valid in that state sets pc to launch_addr and running high on the next cycle, with seq_start high for that one cycle.
- R3: Command codes on cmd_code are: 0 step, 1 jump, 2 branch taken, 3 call, 4 return, 5 exit, 6 terminate, 7 abort. While running, step sets pc to pc+1, and jump or branch set pc to cmd_target. With cmd_valid low, pc holds.
- R4: A call with fewer than DEPTH (default 8) saved entries pushes pc+1 as the return point and loads cmd_target into pc.
- R5: A call with DEPTH entries saved is not performed. call_ovf is high for one cycle, and pc and the stack are unchanged.
- R6: A return with a non-empty stack loads the most recently saved return point into pc and removes it (last in, first out).
- R7: An exit with a non-empty stack behaves exactly like a return. An exit with an empty stack ends the sequence like a terminate and leaves ret_unf low.
- R8: A return with an empty stack raises ret_unf for one cycle and ends the sequence like a terminate.
- R9: Terminate clears the stack. If the pending slot holds an address, pc takes it, running stays high, seq_start is high for one cycle and the slot is emptied. Otherwise running drops and pc holds.
- R10: Abort clears the stack, empties the pending slot, drops running and holds pc. A later terminate or idle period starts nothing from the old slot.
- R11: A launch_valid while running stores launch_addr in the pending slot. A newer launch replaces an older one when PEND_KEEP_FIRST is 0. A launch in the same cycle as a command that ends the sequence (terminate, abort, or return/exit on an empty stack) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A control command is present this cycle |
| cmd_code | input | 3 | Command code (see R3) |
| cmd_target | input | AW | Jump/branch target or resolved call start address |
| launch_valid | input | 1 | Request to run a sequence |
| launch_addr | input | AW | Start address of the requested sequence |
| pc | output | AW | Current program counter |
| running | output | 1 | A sequence is executing |
| seq_start | output | 1 | One-cycle pulse when a sequence begins |
| call_ovf | output | 1 | One-cycle pulse: call refused, stack full |
| ret_unf | output | 1 | One-cycle pulse: return with empty stack |

## Verification
The bench drives random command streams that are weighted toward calls and returns, so the stack often reaches both full and empty. This separates a correct last-in-first-out order and a correct refusal at full from pointer errors that only show up at the ends of the stack. Launches are mixed in at random, both while the engine is idle and while it runs. This shows whether an immediate start, storage in the pending slot, replacement of the stored address, and the launch being ignored on an ending command are told apart correctly. Directed sequences then cover the cases random stimulus seldom reaches: nine nested calls, exit versus return at the top level, terminate with and without a waiting sequence, and an abort followed by a terminate.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

   typedef enum logic [2:0] {
      CMD_STEP   = 3'd0,
      CMD_JUMP   = 3'd1,
      CMD_BRANCH = 3'd2,
      CMD_CALL   = 3'd3,
      CMD_RET    = 3'd4,
      CMD_EXIT   = 3'd5,
      CMD_TERM   = 3'd6,
      CMD_ABORT  = 3'd7
   } cmd_e;

   typedef enum logic [2:0] {
      PC_HOLD,
      PC_INC,
      PC_TGT,
      PC_TOP,
      PC_PEND,
      PC_LNCH
   } pcsel_e;

   typedef struct packed {
      logic   push;
      logic   pop;
      logic   clear;
      logic   pend_take;
      logic   pend_drop;
      logic   pend_load;
      logic   start;
      logic   ovf;
      logic   unf;
      logic   run_nxt;
      pcsel_e pc_sel;
   } ctl_t;

endpackage

// File: rtl/seqctl_stack.sv
module seqctl_stack #(
   parameter int AW    = 16,
   parameter int DEPTH = 8,
   localparam int DW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          clear,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top,
   output logic [DW-1:0] depth,
   output logic          full,
   output logic          empty
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seqctl_stack: DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0] ent [DEPTH];
   logic [DW-1:0] ptr;
   logic [DW-1:0] ptr_m1;

   assign ptr_m1 = ptr - DW'(1);
   assign full   = (ptr == DW'(DEPTH));
   assign empty  = (ptr == '0);
   assign depth  = ptr;
   assign top    = empty ? '0 : ent[ptr_m1[IW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (clear)
         ptr <= '0;
      else if (push && !full)
         ptr <= ptr + DW'(1);
      else if (pop && !empty)
         ptr <= ptr_m1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (push && !clear && ptr == DW'(i))
            ent[i] <= push_data;
      end
   end

endmodule

// File: rtl/seqctl_pend.sv
module seqctl_pend #(
   parameter int AW         = 16,
   parameter bit KEEP_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          take,
   input  logic          drop,
   output logic          valid,
   output logic [AW-1:0] addr
);

   logic wr_en;

   generate
      if (KEEP_FIRST) begin : g_keep_first
         assign wr_en = load && !valid;
      end else begin : g_keep_last
         assign wr_en = load;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
      end else if (take || drop) begin
         valid <= 1'b0;
      end else if (wr_en) begin
         valid <= 1'b1;
         addr  <= load_addr;
      end
   end

endmodule

// File: rtl/seqctl_decide.sv
module seqctl_decide
   import seqctl_pkg::*;
(
   input  logic       running,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       launch_valid,
   input  logic       stk_full,
   input  logic       stk_empty,
   input  logic       pend_valid,
   output ctl_t       ctl
);

   cmd_e cmd;
   logic end_seq;
   logic end_abort;

   assign cmd = cmd_e'(cmd_code);

   always_comb begin
      ctl         = '0;
      ctl.pc_sel  = PC_HOLD;
      ctl.run_nxt = running;
      end_seq     = 1'b0;
      end_abort   = 1'b0;

      if (!running) begin
         if (launch_valid) begin
            ctl.pc_sel  = PC_LNCH;
            ctl.run_nxt = 1'b1;
            ctl.start   = 1'b1;
         end
      end else begin
         if (cmd_valid) begin
            case (cmd)
               CMD_STEP:   ctl.pc_sel = PC_INC;
               CMD_JUMP,
               CMD_BRANCH: ctl.pc_sel = PC_TGT;
               CMD_CALL: begin
                  if (stk_full) begin
                     ctl.ovf = 1'b1;
                  end else begin
                     ctl.push   = 1'b1;
                     ctl.pc_sel = PC_TGT;
                  end
               end
               CMD_RET,
               CMD_EXIT: begin
                  if (!stk_empty) begin
                     ctl.pop    = 1'b1;
                     ctl.pc_sel = PC_TOP;
                  end else begin
                     end_seq = 1'b1;
                     ctl.unf = (cmd == CMD_RET);
                  end
               end
               CMD_TERM:  end_seq   = 1'b1;
               CMD_ABORT: end_abort = 1'b1;
               default:   ctl.pc_sel = PC_HOLD;
            endcase
         end

         if (end_seq) begin
            ctl.clear = 1'b1;
            if (pend_valid) begin
               ctl.pend_take = 1'b1;
               ctl.pc_sel    = PC_PEND;
               ctl.start     = 1'b1;
            end else begin
               ctl.run_nxt = 1'b0;
            end
         end

         if (end_abort) begin
            ctl.clear     = 1'b1;
            ctl.pend_drop = 1'b1;
            ctl.run_nxt   = 1'b0;
         end

         ctl.pend_load = launch_valid && !end_seq && !end_abort;
      end
   end

endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
   import seqctl_pkg::*;
#(
   parameter int          AW              = 16,
   parameter int          DEPTH           = 8,
   parameter logic [15:0] RESET_PC        = 16'h0000,
   parameter bit          PEND_KEEP_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_code,
   input  logic [AW-1:0] cmd_target,
   input  logic          launch_valid,
   input  logic [AW-1:0] launch_addr,
   output logic [AW-1:0] pc,
   output logic          running,
   output logic          seq_start,
   output logic          call_ovf,
   output logic          ret_unf
);

   localparam int DW = $clog2(DEPTH + 1);

   generate
      if (AW < 2 || AW > 64) begin : g_bad_aw
         $error("seqctl_top: AW must be 2..64");
      end
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("seqctl_top: DEPTH must be 2..256");
      end
   endgenerate

   ctl_t          ctl;
   logic [AW-1:0] stk_top;
   logic [DW-1:0] stk_depth;
   logic          stk_full;
   logic          stk_empty;
   logic          pend_valid;
   logic [AW-1:0] pend_addr;
   logic [AW-1:0] pc_inc;
   logic [AW-1:0] pc_nxt;

   assign pc_inc = pc + AW'(1);

   seqctl_decide u_dec (
      .running      (running),
      .cmd_valid    (cmd_valid),
      .cmd_code     (cmd_code),
      .launch_valid (launch_valid),
      .stk_full     (stk_full),
      .stk_empty    (stk_empty),
      .pend_valid   (pend_valid),
      .ctl          (ctl)
   );

   seqctl_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ctl.push),
      .pop       (ctl.pop),
      .clear     (ctl.clear),
      .push_data (pc_inc),
      .top       (stk_top),
      .depth     (stk_depth),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   seqctl_pend #(.AW(AW), .KEEP_FIRST(PEND_KEEP_FIRST)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ctl.pend_load),
      .load_addr (launch_addr),
      .take      (ctl.pend_take),
      .drop      (ctl.pend_drop),
      .valid     (pend_valid),
      .addr      (pend_addr)
   );

   always_comb begin
      case (ctl.pc_sel)
         PC_INC:  pc_nxt = pc_inc;
         PC_TGT:  pc_nxt = cmd_target;
         PC_TOP:  pc_nxt = stk_top;
         PC_PEND: pc_nxt = pend_addr;
         PC_LNCH: pc_nxt = launch_addr;
         default: pc_nxt = pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc        <= AW'(RESET_PC);
         running   <= 1'b0;
         seq_start <= 1'b0;
         call_ovf  <= 1'b0;
         ret_unf   <= 1'b0;
      end else begin
         pc        <= pc_nxt;
         running   <= ctl.run_nxt;
         seq_start <= ctl.start;
         call_ovf  <= ctl.ovf;
         ret_unf   <= ctl.unf;
      end
   end

endmodule

// File: rtl/seqctl_chk.sv
module seqctl_chk #(
   parameter int AW    = 16,
   parameter int DEPTH = 8,
   localparam int DW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [2:0]    cmd_code,
   input logic [AW-1:0] cmd_target,
   input logic          launch_valid,
   input logic [AW-1:0] pc,
   input logic          running,
   input logic          seq_start,
   input logic          call_ovf,
   input logic          ret_unf,
   input logic [DW-1:0] stk_depth,
   input logic [AW-1:0] stk_top,
   input logic          pend_valid,
   input logic [AW-1:0] pend_addr
);

   logic act;
   assign act = running && cmd_valid;

   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !launch_valid) |=> (!running && $stable(pc)));

   a_r2_start_while_running: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> running);

   a_r4_call_push: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cmd_code == 3'd3 && stk_depth < DW'(DEPTH))
      |=> (pc == $past(cmd_target) && stk_depth == $past(stk_depth) + DW'(1)));

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cmd_code == 3'd3 && stk_depth == DW'(DEPTH))
      |=> (call_ovf && $stable(pc) && $stable(stk_depth)));

   a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      stk_depth <= DW'(DEPTH));

   a_r6_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cmd_code == 3'd4 && stk_depth != '0)
      |=> (pc == $past(stk_top) && !ret_unf));

   a_r8_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cmd_code == 3'd4 && stk_depth == '0) |=> (ret_unf && stk_depth == '0));

   a_r9_term_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cmd_code == 3'd6 && pend_valid)
      |=> (seq_start && running && pc == $past(pend_addr) && stk_depth == '0));

   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cmd_code == 3'd7)
      |=> (!running && !pend_valid && stk_depth == '0 && $stable(pc)));

endmodule

bind seqctl_top seqctl_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_code     (cmd_code),
   .cmd_target   (cmd_target),
   .launch_valid (launch_valid),
   .pc           (pc),
   .running      (running),
   .seq_start    (seq_start),
   .call_ovf     (call_ovf),
   .ret_unf      (ret_unf),
   .stk_depth    (stk_depth),
   .stk_top      (stk_top),
   .pend_valid   (pend_valid),
   .pend_addr    (pend_addr)
);

// File: tb/sim_seqctl_top.sv
`timescale 1ns/1ps
module sim_seqctl_top;

   localparam int AW    = 16;
   localparam int DEPTH = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_code = '0;
   logic [AW-1:0] cmd_target = '0;
   logic          launch_valid = 1'b0;
   logic [AW-1:0] launch_addr = '0;
   logic [AW-1:0] pc;
   logic          running, seq_start, call_ovf, ret_unf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [AW-1:0] m_pc = '0;
   bit            m_run = 1'b0;
   logic [AW-1:0] m_st [DEPTH];
   int            m_dep = 0;
   bit            m_pv = 1'b0;
   logic [AW-1:0] m_pend = '0;
   bit            e_start, e_ovf, e_unf;
   string         m_tag;

   always #2.5 clk = ~clk;

   seqctl_top #(.AW(AW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_target(cmd_target), .launch_valid(launch_valid), .launch_addr(launch_addr),
      .pc(pc), .running(running), .seq_start(seq_start), .call_ovf(call_ovf),
      .ret_unf(ret_unf)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic m_end();
      m_dep = 0;
      if (m_pv) begin
         m_pc = m_pend; m_pv = 1'b0; e_start = 1'b1;
      end else begin
         m_run = 1'b0;
      end
   endtask

   task automatic model(input bit v, input logic [2:0] c, input logic [AW-1:0] t,
                        input bit lv, input logic [AW-1:0] la);
      bit ending = 1'b0;
      e_start = 1'b0; e_ovf = 1'b0; e_unf = 1'b0;
      m_tag = "R3";
      if (!m_run) begin
         m_tag = "R2";
         if (lv) begin m_pc = la; m_run = 1'b1; e_start = 1'b1; end
      end else begin
         if (v) begin
            case (c)
               3'd0: m_pc = m_pc + 1'b1;
               3'd1, 3'd2: m_pc = t;
               3'd3: begin
                  if (m_dep == DEPTH) begin e_ovf = 1'b1; m_tag = "R5"; end
                  else begin m_st[m_dep] = m_pc + 1'b1; m_dep++; m_pc = t; m_tag = "R4"; end
               end
               3'd4, 3'd5: begin
                  m_tag = (c == 3'd4) ? "R6" : "R7";
                  if (m_dep > 0) begin m_dep--; m_pc = m_st[m_dep]; end
                  else begin
                     ending = 1'b1; e_unf = (c == 3'd4);
                     if (c == 3'd4) m_tag = "R8";
                     m_end();
                  end
               end
               3'd6: begin ending = 1'b1; m_tag = "R9"; m_end(); end
               default: begin
                  ending = 1'b1; m_tag = "R10";
                  m_dep = 0; m_pv = 1'b0; m_run = 1'b0;
               end
            endcase
         end
         if (lv && !ending) begin m_pend = la; m_pv = 1'b1; end
         else if (lv) m_tag = "R11";
      end
   endtask

   task automatic step(input bit v, input logic [2:0] c, input logic [AW-1:0] t,
                       input bit lv, input logic [AW-1:0] la);
      @(negedge clk);
      cmd_valid = v; cmd_code = c; cmd_target = t; launch_valid = lv; launch_addr = la;
      model(v, c, t, lv, la);
      @(posedge clk);
      #1;
      check({m_tag, " pc"}, 64'(pc), 64'(m_pc));
      check({m_tag, " running"}, 64'(running), 64'(m_run));
      check({m_tag, " seq_start"}, 64'(seq_start), 64'(e_start));
      check({m_tag, " call_ovf"}, 64'(call_ovf), 64'(e_ovf));
      check({m_tag, " ret_unf"}, 64'(ret_unf), 64'(e_unf));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      check("R1 pc", 64'(pc), 64'h0);
      check("R1 running", 64'(running), 64'h0);
      check("R1 pulses", 64'({seq_start, call_ovf, ret_unf}), 64'h0);
      @(negedge clk); rst_n = 1'b1;
      // R2 idle: commands ignored
      step(1, 3'd1, 16'h1234, 0, 16'h0);
      step(1, 3'd3, 16'h2222, 0, 16'h0);
      // R2 launch
      step(0, 3'd0, 16'h0, 1, 16'h0100);
      // R3 step, jump, branch, hold
      step(1, 3'd0, 16'h0, 0, 16'h0);
      step(0, 3'd1, 16'h5555, 0, 16'h0);
      step(1, 3'd2, 16'h0200, 0, 16'h0);
      // R4/R5 nine nested calls
      for (int i = 0; i < DEPTH + 1; i++) step(1, 3'd3, 16'(16'h1000 + i * 16), 0, 16'h0);
      // R6 unwind, then R8 return with empty stack (no pending: stops)
      for (int i = 0; i < DEPTH; i++) step(1, 3'd4, 16'h0, 0, 16'h0);
      step(1, 3'd4, 16'h0, 0, 16'h0);
      // R7 exit after a call acts as return; at top level ends, no ret_unf
      step(0, 3'd0, 16'h0, 1, 16'h0300);
      step(1, 3'd3, 16'h0400, 0, 16'h0);
      step(1, 3'd5, 16'h0, 0, 16'h0);
      step(1, 3'd5, 16'h0, 0, 16'h0);
      // R9/R11 terminate with pending; newer launch replaces older
      step(0, 3'd0, 16'h0, 1, 16'h0500);
      step(1, 3'd3, 16'h0600, 1, 16'h0A00);
      step(1, 3'd0, 16'h0, 1, 16'h0B00);
      step(1, 3'd6, 16'h0, 1, 16'h0C00);   // launch ignored on ending cycle
      step(1, 3'd4, 16'h0, 0, 16'h0);      // stack was cleared: underflow
      // R10 abort discards pending
      step(0, 3'd0, 16'h0, 1, 16'h0700);
      step(1, 3'd0, 16'h0, 1, 16'h0D00);
      step(1, 3'd7, 16'h0, 0, 16'h0);
      step(1, 3'd6, 16'h0, 0, 16'h0);
      step(0, 3'd0, 16'h0, 0, 16'h0);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom_range(0, 99));
         logic [2:0] c;
         if (r < 25) c = 3'd0;
         else if (r < 33) c = 3'd1;
         else if (r < 40) c = 3'd2;
         else if (r < 65) c = 3'd3;
         else if (r < 82) c = 3'd4;
         else if (r < 93) c = 3'd5;
         else if (r < 97) c = 3'd6;
         else c = 3'd7;
         step(($urandom_range(0, 9) != 0), c, 16'($urandom),
              ($urandom_range(0, 9) < (m_run ? 1 : 5)), 16'($urandom));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule